// File: doc/BRIEF.md
# Lockable Flash Component Property Register

This block is a 32-bit control register that describes one serial flash component to the rest of a flash controller. It holds two 8-bit erase opcodes (4 KB and 64 KB granularity), six capability flags, a 3-bit code that says how the device's quad-enable bit is handled, and three write-behaviour bits. Software updates it through a plain write strobe with a full 32-bit data word. A discovery engine, after it has parsed the device's parameter tables, loads it through a second strobe. The stored value is always visible on the read port.

The register has two protection sources. The first is a vendor lock bit that software sets itself and cannot clear again before reset. The second is a discovery-valid flag that hardware sets on every discovery load. Each field has its own set of locks that apply to it. Discovery loads ignore both locks. Both strobes are accepted in every cycle and there is no back-pressure. The stored value changes at the clock edge that samples a strobe, and the read port shows the new value from the next cycle on.

Top module: `fcp_prop_reg`

## Requirements
- R1: After reset the read port shows 0x0000_2000. The 4 KB erase opcode in bits 15:8 resets to 0x20, and every other bit resets to 0.
- R2: Bit 30 is the vendor lock. A software write that carries a 1 in bit 30 sets it. Once the lock is set, no software write clears it, and it stays set until reset.
- R3: Bit 31 is the discovery-valid flag. Software writes never change it. A discovery load sets it, the read port shows the 1 in the cycle after the load strobe, and it stays set until reset.
- R4: Software writes to bits 23:16 (64 KB erase opcode), bits 15:8 (4 KB erase opcode) and bits 4:2 have no effect while bit 30 or bit 31 is set.
- R5: Software writes to bits 7:5 (quad-enable method code) have no effect while bit 30 is set. Bit 31 does not lock these bits.
- R6: Bits 29:24 hold the capability flags. From high to low they are: 64 KB erase valid, 4 KB erase valid, replay-protected counter support, deep power-down support, suspend/resume support, and soft reset support. Software can write them while bit 30 is clear, and bit 31 does not lock them.
- R7: Bits 1:0 always read 0.
- R8: A discovery load copies bits 29:28, 26:24 and 23:2 from the discovery data, whatever the lock state. It never changes bit 27 or bit 30.
- R9: When a discovery load and a software write fall in the same cycle, the discovery data wins on the bits the load updates. The software write still acts on bit 27 and bit 30 if the locks that held before that cycle allow it. A lock state is only checked as it stood before the cycle of the write.
- R10: When no strobe is active, the stored value does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Software write strobe |
| cfg_wr_data | input | 32 | Software write data |
| disc_ld | input | 1 | Discovery load strobe |
| disc_data | input | 32 | Discovery load data |
| prop_q | output | 32 | Current register contents |

## Verification
The assertions expect both strobes to be clean 0/1 levels once reset is released. They make no assumption about how often the strobes arrive or whether they arrive together. The lock-hold properties fire only in cycles with no discovery load, because a load is allowed to override the locks.

The stimulus meets these expectations by driving every input at the falling edge. It pulses reset between random epochs so that both unlocked and locked states are reached many times. It also sets the lock bit and the load strobe with low probability, so that long stretches of unlocked writes come before each lock event.

// File: rtl/fcp_pkg.sv
package fcp_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned OPC_W    = 8;
  localparam int unsigned VLOCK_B  = 30;
  localparam int unsigned DVALID_B = 31;

  // bits writable by software unless the vendor lock is set
  localparam logic [REG_W-1:0] M_VLOCK_ONLY = 32'h7F00_00E0;
  // bits writable by software unless either lock is set
  localparam logic [REG_W-1:0] M_BOTH_LOCKS = 32'h00FF_FF1C;
  // bits loaded by the discovery port
  localparam logic [REG_W-1:0] M_DISC       = 32'h37FF_FFFC;

  function automatic logic [REG_W-1:0] reset_word(input logic [OPC_W-1:0] e4k);
    logic [REG_W-1:0] w;
    w = '0;
    w[15:8] = e4k;
    return w;
  endfunction
endpackage

// File: rtl/fcp_lock_ctrl.sv
module fcp_lock_ctrl
  import fcp_pkg::*;
(
  input  logic             cur_vlock,
  input  logic             cur_dvalid,
  input  logic             sw_wr,
  input  logic             hw_ld,
  input  logic [REG_W-1:0] hw_data,
  output logic [REG_W-1:0] sw_we,
  output logic [REG_W-1:0] hw_we,
  output logic [REG_W-1:0] hw_d
);
  logic [REG_W-1:0] allow;
  logic [REG_W-1:0] set_dv;

  always_comb begin
    allow = '0;
    if (!cur_vlock) begin
      allow = allow | M_VLOCK_ONLY;
      if (!cur_dvalid) allow = allow | M_BOTH_LOCKS;
    end
    set_dv = '0;
    set_dv[DVALID_B] = 1'b1;
  end

  assign sw_we = {REG_W{sw_wr}} & allow;
  assign hw_we = {REG_W{hw_ld}} & (M_DISC | set_dv);
  assign hw_d  = (hw_data & M_DISC) | set_dv;
endmodule

// File: rtl/fcp_bit_store.sv
module fcp_bit_store
  import fcp_pkg::*;
#(
  parameter logic [REG_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] sw_we,
  input  logic [REG_W-1:0] sw_d,
  input  logic [REG_W-1:0] hw_we,
  input  logic [REG_W-1:0] hw_d,
  output logic [REG_W-1:0] q
);
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q[i] <= RST_VAL[i];
      else if (hw_we[i]) q[i] <= hw_d[i];
      else if (sw_we[i]) q[i] <= sw_d[i];
    end
  end
endmodule

// File: rtl/fcp_prop_reg.sv
module fcp_prop_reg
  import fcp_pkg::*;
#(
  parameter logic [OPC_W-1:0] ERASE4K_RST = 8'h20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wr_data,
  input  logic             disc_ld,
  input  logic [REG_W-1:0] disc_data,
  output logic [REG_W-1:0] prop_q
);
  localparam logic [REG_W-1:0] RST_WORD = reset_word(ERASE4K_RST);

  logic [REG_W-1:0] sw_we, hw_we, hw_d, q;

  fcp_lock_ctrl u_lock (
    .cur_vlock (q[VLOCK_B]),
    .cur_dvalid(q[DVALID_B]),
    .sw_wr     (cfg_wr_en),
    .hw_ld     (disc_ld),
    .hw_data   (disc_data),
    .sw_we     (sw_we),
    .hw_we     (hw_we),
    .hw_d      (hw_d)
  );

  fcp_bit_store #(.RST_VAL(RST_WORD)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .sw_we(sw_we),
    .sw_d (cfg_wr_data),
    .hw_we(hw_we),
    .hw_d (hw_d),
    .q    (q)
  );

  assign prop_q = q;
endmodule

// File: rtl/fcp_prop_reg_chk.sv
module fcp_prop_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr_en,
  input logic [31:0] cfg_wr_data,
  input logic        disc_ld,
  input logic [31:0] disc_data,
  input logic [31:0] prop_q
);
  p_vlock_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prop_q[30] |=> prop_q[30]);
  p_dvalid_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prop_q[31] |=> prop_q[31]);
  p_dvalid_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    disc_ld |=> prop_q[31]);
  p_opcode_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((prop_q[30] || prop_q[31]) && !disc_ld) |=> ($stable(prop_q[23:8]) && $stable(prop_q[4:2])));
  p_qer_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (prop_q[30] && !disc_ld) |=> ($stable(prop_q[7:5]) && $stable(prop_q[29:24])));
  p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prop_q[1:0] == 2'b00);
  p_disc_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    disc_ld |=> (prop_q[23:2] == $past(disc_data[23:2]) &&
                 prop_q[29:28] == $past(disc_data[29:28]) &&
                 prop_q[26:24] == $past(disc_data[26:24])));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr_en && !disc_ld) |=> $stable(prop_q));
endmodule

bind fcp_prop_reg fcp_prop_reg_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr_en  (cfg_wr_en),
  .cfg_wr_data(cfg_wr_data),
  .disc_ld    (disc_ld),
  .disc_data  (disc_data),
  .prop_q     (prop_q)
);

// File: tb/fcp_prop_reg_tb.sv
`timescale 1ns/1ps
module fcp_prop_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wr_data = '0;
  logic        disc_ld = 1'b0;
  logic [31:0] disc_data = '0;
  logic [31:0] prop_q;

  int unsigned total = 0;
  int unsigned bad = 0;
  logic [31:0] exp_q;
  bit done = 0;

  always #2 clk = ~clk;

  fcp_prop_reg u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .disc_ld(disc_ld), .disc_data(disc_data), .prop_q(prop_q)
  );

  function automatic logic [31:0] model(input logic [31:0] cur, input logic sw,
      input logic [31:0] swd, input logic dl, input logic [31:0] dd);
    logic [31:0] n;
    n = cur;
    if (sw && !cur[30]) begin
      n[30] = swd[30] | cur[30];
      n[29:24] = swd[29:24];
      n[7:5] = swd[7:5];
      if (!cur[31]) begin
        n[23:8] = swd[23:8];
        n[4:2] = swd[4:2];
      end
    end
    if (dl) begin
      n[31] = 1'b1;
      n[29:28] = dd[29:28];
      n[26:24] = dd[26:24];
      n[23:2] = dd[23:2];
    end
    n[1:0] = 2'b00;
    return n;
  endfunction

  function automatic string req_of(input logic [31:0] d);
    if (d[31]) return "R3";
    if (d[30]) return "R2";
    if (d[27]) return "R9";
    if (|d[29:24]) return "R6";
    if (|d[23:8] || |d[4:2]) return "R4";
    if (|d[7:5]) return "R5";
    if (|d[1:0]) return "R7";
    return "R10";
  endfunction

  task automatic check(input string tag);
    total++;
    if (prop_q !== exp_q) begin
      bad++;
      $display("FAIL %s: prop_q=%08h expected=%08h", tag, prop_q, exp_q);
    end
  endtask

  // called at a falling edge; applies one cycle of stimulus, checks after the edge
  task automatic step(input logic sw, input logic [31:0] swd, input logic dl,
                      input logic [31:0] dd, input string tag);
    cfg_wr_en = sw; cfg_wr_data = swd; disc_ld = dl; disc_data = dd;
    exp_q = model(exp_q, sw, swd, dl, dd);
    @(negedge clk);
    cfg_wr_en = 1'b0; disc_ld = 1'b0;
    check(tag == "" ? req_of(prop_q ^ exp_q) : tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cfg_wr_en = 1'b0; disc_ld = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    exp_q = 32'h0000_2000;
    @(negedge clk);
    check("R1");
  endtask

  initial begin
    void'($urandom(32'd1234));
    exp_q = 32'h0000_2000;
    @(negedge clk);
    do_reset();

    // unlocked writes, reserved bits stay 0
    step(1, 32'hBFFF_FFFF, 0, 0, "R7");
    step(1, 32'h0000_0000, 0, 0, "R6");
    step(0, 32'hFFFF_FFFF, 0, 32'hFFFF_FFFF, "R10");
    step(1, 32'h3A5A_C3E8, 0, 0, "R4");
    // set vendor lock then try to modify and clear
    step(1, 32'h4000_0000, 0, 0, "R2");
    step(1, 32'h0000_0000, 0, 0, "R2");
    step(1, 32'h3FFF_FFFF, 0, 0, "R5");
    // discovery load bypasses vendor lock, leaves bit 27 and 30
    step(0, 0, 1, 32'hFFFF_FFFF, "R8");
    step(0, 0, 1, 32'h0000_0000, "R8");

    // discovery-valid locks opcodes, not QER/caps
    do_reset();
    step(0, 0, 1, 32'h2C12_3458, "R3");
    step(1, 32'hFFFF_FFFF & ~32'h4000_0000, 0, 0, "R4");
    step(1, 32'h0000_00E0, 0, 0, "R5");
    step(1, 32'h3F00_0000, 0, 0, "R6");
    step(1, 32'h8000_0000, 0, 0, "R3");

    // same-cycle precedence
    do_reset();
    step(1, 32'h4FFF_FFFF, 1, 32'h0000_0000, "R9");
    step(1, 32'h0000_0000, 0, 0, "R9");

    // random epochs
    for (int e = 0; e < 12; e++) begin
      do_reset();
      for (int c = 0; c < 300; c++) begin
        logic sw, dl;
        logic [31:0] swd, dd;
        sw = ($urandom % 2) == 0;
        dl = ($urandom % 30) == 0;
        swd = $urandom;
        swd[30] = ($urandom % 25) == 0;
        dd = $urandom;
        step(sw, swd, dl, dd, "");
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule